// File: doc/BRIEF.md
# Two-Channel Output Compare with Software-Forced Levels

This block sits next to a free-running counter and watches its value on two independent compare channels. Each channel holds a compare value, loaded one byte at a time through a narrow register port. When a channel's compare value equals the counter, the channel latches a status flag. It also moves its output pin to a level chosen by software. Software can instead force a channel's pin to follow its level bit directly. Forcing does not touch the status flag, so the pin can be driven without any interrupt.

The same port gives access to two capture channels. Each capture channel stores the counter value when its event strobe pulses. The compare and capture registers are wider than the data bus, so a partial access must not leave a half-updated value active. Writing the upper byte of a compare value suspends that channel's compare until the lower byte arrives. Reading the upper byte of a captured value freezes that capture until the lower byte has been read.

Two mode inputs from neighbouring pulse logic (pulse-width and single-pulse generation) override forcing on channel 1 only.

Top module: `oc_force_unit`

## Requirements
- R1: After reset both pins are low, `irq` is low, both flags are clear, both compare values are all ones and armed, and both capture values are zero and unlocked.
- R2: With forcing off, a cycle in which an armed channel's compare value equals `cnt_in` sets that channel's flag and latches its level bit as the pin state, both visible after that clock edge.
- R3: A channel whose output-enable bit is 0 drives its pin low. Its latched pin state reappears when the enable is set again.
- R4: While its force bit is set, channel 1's pin state follows its level bit on every clock, but only while `pwm_mode` and `onepulse_mode` are both low. If either mode input is high, the force bit has no effect and the pin holds.
- R5: While its force bit is set, channel 2's pin state follows its level bit on every clock, whatever the mode inputs are.
- R6: Forcing a level never sets a flag and never raises `irq`.
- R7: A real counter match on a channel whose force bit is set still sets that channel's flag.
- R8: Writing a compare upper byte disarms that channel, so matches are ignored. Writing the lower byte re-arms it.
- R9: A flag clears only when a status read made while the flag was set is followed by a read or write of that channel's compare lower byte. An access to the lower byte with no such status read leaves the flag set. A match in the clearing cycle wins.
- R10: `irq` is high whenever some channel has both its flag and its interrupt-enable bit set, and low otherwise.
- R11: A capture strobe stores `cnt_in` into that capture register unless the channel is locked. Reading its upper byte locks it, and reading its lower byte unlocks it.
- R12: The register map is as follows. Address 0 is control: bits 0/1 output-enable ch1/ch2, bits 2/3 level, bits 4/5 force, bits 6/7 interrupt-enable. Address 1 is status: bit 0 flag ch1, bit 1 flag ch2, read-only. Addresses 2/3 are the ch1 compare upper/lower bytes, 4/5 the ch2 compare bytes, 6/7 the ch1 capture bytes, and 8/9 the ch2 capture bytes. `reg_rdata` reflects `reg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_in | input | 16 | Free-running counter value |
| pwm_mode | input | 1 | Pulse-width mode active; blocks channel 1 forcing |
| onepulse_mode | input | 1 | Single-pulse mode active; blocks channel 1 forcing |
| cap_evt | input | 2 | Capture strobes, one per capture channel |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| cmp_out | output | 2 | Compare output pins, bit 0 is channel 1 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 8-bit data width, which gives 16-bit compare and capture values. At this width, each counter match can be placed exactly by driving `cnt_in` to the written value for one cycle. The split-byte locking is exercised with upper and lower bytes that differ, so a stale half is visible. The same width makes every register reachable at the fixed ten-address map. That covers the force and mode interplay on channel 1 against channel 2, and the two-step flag clear, including its missing-status-read case.

// File: rtl/oc_pkg.sv
// Package: shared constants for the two-channel output compare unit.
// Assumes a fixed ten-entry register map and two channels of each kind.
package oc_pkg;
    localparam int ADDR_W   = 4;
    localparam int NUM_CH   = 2;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 4'd2; // ch g upper byte at A_CMP_HI + 2g
    localparam logic [ADDR_W-1:0] A_CAP_HI = 4'd6; // ch g upper byte at A_CAP_HI + 2g

    // Control bit positions, per channel g add g
    localparam int B_OE  = 0;
    localparam int B_LVL = 2;
    localparam int B_FRC = 4;
    localparam int B_IE  = 6;
endpackage

// File: rtl/oc_cmp_chan.sv
// Module: one compare channel.
// Holds a split-loaded compare value, arms and disarms it on byte writes,
// detects a match, keeps the status flag with its two-step clear and the pin state.
// Assumes strobes are one-cycle pulses already decoded by the parent.
module oc_cmp_chan #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hi_wr,
    input  logic              lo_wr,
    input  logic              lo_acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_rd,
    input  logic              force_en,
    input  logic              level,
    input  logic              oe,
    output logic              flag,
    output logic              armed,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              pin
);
    logic seen_q;
    logic pin_q;
    logic match;

    // A match counts only while both bytes of the value are in place.
    assign match = armed && (cnt == cmp_val);

    // Compare value bytes and the arm state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '1;
            armed   <= 1'b1;
        end else if (hi_wr) begin
            cmp_val[CNT_W-1:DATA_W] <= wdata;
            armed                   <= 1'b0;
        end else if (lo_wr) begin
            cmp_val[DATA_W-1:0] <= wdata;
            armed               <= 1'b1;
        end
    end

    // Flag: set by a match, cleared by a status read followed by a lower-byte access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            if (lo_acc && seen_q) begin
                flag   <= 1'b0;
                seen_q <= 1'b0;
            end else if (stat_rd && flag) begin
                seen_q <= 1'b1;
            end
            if (match) begin
                flag <= 1'b1;
            end
        end
    end

    // Pin state: follows the level when forced or on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (force_en || match) begin
            pin_q <= level;
        end
    end

    assign pin = oe & pin_q;
endmodule

// File: rtl/oc_cap_chan.sv
// Module: one capture channel.
// Stores the counter on a strobe unless locked by an upper-byte read that
// has not yet been followed by a lower-byte read.
// Assumes the read strobes are one-cycle pulses.
module oc_cap_chan #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             evt,
    input  logic             hi_rd,
    input  logic             lo_rd,
    output logic [CNT_W-1:0] cap_val,
    output logic             locked
);
    // Lock tracking across the split read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
        end else if (hi_rd) begin
            locked <= 1'b1;
        end else if (lo_rd) begin
            locked <= 1'b0;
        end
    end

    // Capture storage, frozen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_val <= '0;
        end else if (evt && !locked) begin
            cap_val <= cnt;
        end
    end
endmodule

// File: rtl/oc_force_unit.sv
// Module: two-channel output compare unit with forced levels, plus
// split-access capture storage, behind an 8-bit register port.
// Assumes cnt_in is a free-running counter supplied by a neighbour
// and that only one register access happens per cycle.
module oc_force_unit #(
    parameter int DATA_W = 8,
    localparam int CNT_W = 2 * DATA_W,
    localparam int ADDR_W = oc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              pwm_mode,
    input  logic              onepulse_mode,
    input  logic [1:0]        cap_evt,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        cmp_out,
    output logic              irq
);
    import oc_pkg::*;

    logic [7:0]                   ctrl_q;
    logic [NUM_CH-1:0]            flag_v;
    logic [NUM_CH-1:0]            armed_v;
    logic [NUM_CH-1:0]            lock_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cap_v;
    logic                         stat_rd;

    assign stat_rd = reg_rd && (reg_addr == A_STAT);

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr && reg_addr == A_CTRL) begin
            ctrl_q <= reg_wdata[7:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] CHI = A_CMP_HI + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] CLO = CHI + ADDR_W'(1);
        localparam logic [ADDR_W-1:0] PHI = A_CAP_HI + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] PLO = PHI + ADDR_W'(1);
        logic force_eff;

        if (g == 0) begin : g_blocked
            // Channel 1 forcing yields to the pulse modes.
            assign force_eff = ctrl_q[B_FRC+g] && !pwm_mode && !onepulse_mode;
        end else begin : g_free
            assign force_eff = ctrl_q[B_FRC+g];
        end

        oc_cmp_chan #(.DATA_W(DATA_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt_in),
            .hi_wr    (reg_wr && reg_addr == CHI),
            .lo_wr    (reg_wr && reg_addr == CLO),
            .lo_acc   ((reg_wr || reg_rd) && reg_addr == CLO),
            .wdata    (reg_wdata),
            .stat_rd  (stat_rd),
            .force_en (force_eff),
            .level    (ctrl_q[B_LVL+g]),
            .oe       (ctrl_q[B_OE+g]),
            .flag     (flag_v[g]),
            .armed    (armed_v[g]),
            .cmp_val  (cmp_v[g]),
            .pin      (cmp_out[g])
        );

        oc_cap_chan #(.DATA_W(DATA_W)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt_in),
            .evt     (cap_evt[g]),
            .hi_rd   (reg_rd && reg_addr == PHI),
            .lo_rd   (reg_rd && reg_addr == PLO),
            .cap_val (cap_v[g]),
            .locked  (lock_v[g])
        );
    end

    // Interrupt request from enabled flags.
    assign irq = |(flag_v & {ctrl_q[B_IE+1], ctrl_q[B_IE]});

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            4'd0: reg_rdata = DATA_W'(ctrl_q);
            4'd1: reg_rdata = DATA_W'(flag_v);
            4'd2: reg_rdata = cmp_v[0][CNT_W-1:DATA_W];
            4'd3: reg_rdata = cmp_v[0][DATA_W-1:0];
            4'd4: reg_rdata = cmp_v[1][CNT_W-1:DATA_W];
            4'd5: reg_rdata = cmp_v[1][DATA_W-1:0];
            4'd6: reg_rdata = cap_v[0][CNT_W-1:DATA_W];
            4'd7: reg_rdata = cap_v[0][DATA_W-1:0];
            4'd8: reg_rdata = cap_v[1][CNT_W-1:DATA_W];
            4'd9: reg_rdata = cap_v[1][DATA_W-1:0];
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/oc_force_chk.sv
// Checker: temporal properties of the output compare unit, bound to its top.
module oc_force_chk #(
    parameter int CNT_W = 16,
    parameter int ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [CNT_W-1:0]       cnt_in,
    input logic [1:0]             cmp_out,
    input logic                   irq,
    input logic [7:0]             ctrl_q,
    input logic [1:0]             flag_v,
    input logic [1:0]             armed_v,
    input logic [1:0]             lock_v,
    input logic [1:0][CNT_W-1:0]  cmp_v,
    input logic [1:0][CNT_W-1:0]  cap_v
);
    // Disabled output stays low.
    assert_oe_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> !cmp_out[0]);

    // A flag only rises after a genuine armed match, never from forcing.
    assert_flag_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_v[0]) |-> $past(armed_v[0] && cnt_in == cmp_v[0]));

    assert_flag2_needs_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_v[1]) |-> $past(armed_v[1] && cnt_in == cmp_v[1]));

    // Upper-byte write disarms.
    assert_hi_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd2) |=> !armed_v[0]);

    // Locked capture holds its value.
    assert_lock_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_v[0] |=> $stable(cap_v[0]));

    // Channel 2 forcing follows the level regardless of modes.
    assert_force2_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[5]) |=> (!ctrl_q[1] || cmp_out[1] == $past(ctrl_q[3])));

    // Interrupt only with a pending flag.
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_v != 2'b00));
endmodule

bind oc_force_unit oc_force_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .cnt_in   (cnt_in),
    .cmp_out  (cmp_out),
    .irq      (irq),
    .ctrl_q   (ctrl_q),
    .flag_v   (flag_v),
    .armed_v  (armed_v),
    .lock_v   (lock_v),
    .cmp_v    (cmp_v),
    .cap_v    (cap_v)
);

// File: tb/oc_force_unit_bench.sv
// Bench: scoreboard style. The driver pushes expected items, a monitor pops
// and compares them against the live outputs.
module oc_force_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_in = '0;
    logic        pwm_mode = 1'b0;
    logic        onepulse_mode = 1'b0;
    logic [1:0]  cap_evt = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [1:0]  cmp_out;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 pins, 1 irq, 2 read data
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];
    event  ev_chk;

    always #4 clk = ~clk;   // 125 MHz

    oc_force_unit u_oc_force_unit (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .pwm_mode(pwm_mode),
        .onepulse_mode(onepulse_mode), .cap_evt(cap_evt), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_out(cmp_out), .irq(irq)
    );

    // Monitor: pop expected items and compare.
    initial begin
        forever begin
            @(ev_chk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = {14'd0, cmp_out};
                    1:       act = {15'd0, irq};
                    default: act = {8'd0, reg_rdata};
                endcase
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [15:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        #1 -> ev_chk;
        wait (sb_q.size() == 0);
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    // Read with side effects; checks data before the edge.
    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        reg_addr = a; reg_rd = 1'b1;
        push(2, {8'd0, exp}, req);
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic match_at(input logic [15:0] v);
        cnt_in = v; tick(); cnt_in = 16'h0000;
    endtask

    task automatic cap_at(input int ch, input logic [15:0] v);
        cnt_in = v; cap_evt[ch] = 1'b1; tick(); cap_evt = '0; cnt_in = 16'h0000;
    endtask

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push(0, 16'h0, "R1 pins after reset");
        push(1, 16'h0, "R1 irq after reset");
        rd(4'd1, 8'h00, "R1 status after reset");
        rd(4'd2, 8'hFF, "R1 compare reset value");
        rd(4'd7, 8'h00, "R1 capture reset value");

        // R2 plain match
        wr(4'd0, 8'h45);
        rd(4'd0, 8'h45, "R12 control readback");
        wr(4'd2, 8'h12); wr(4'd3, 8'h34);
        match_at(16'h1234);
        push(0, 16'h1, "R2 pin takes level on match");
        push(1, 16'h1, "R10 irq with flag and enable");
        rd(4'd1, 8'h01, "R2 flag set on match");
        rd(4'd3, 8'h34, "R9 clearing access");
        rd(4'd1, 8'h00, "R9 flag cleared");
        push(1, 16'h0, "R9 irq dropped");

        // R9 access without status read keeps the flag
        match_at(16'h1234);
        rd(4'd3, 8'h34, "R9 lower access without status read");
        rd(4'd1, 8'h01, "R9 flag kept");
        rd(4'd3, 8'h34, "R9 clearing access");
        push(1, 16'h0, "R9 irq dropped after clear");

        // R8 disarm on upper write
        wr(4'd2, 8'h20);
        match_at(16'h2034);
        rd(4'd1, 8'h00, "R8 no flag while disarmed");
        wr(4'd3, 8'h34);
        match_at(16'h2034);
        rd(4'd1, 8'h01, "R8 flag after re-arm");
        rd(4'd3, 8'h34, "R9 clearing access");

        // R3 output enable
        wr(4'd0, 8'h44);
        push(0, 16'h0, "R3 disabled pin low");
        wr(4'd0, 8'h45);
        push(0, 16'h1, "R3 state returns on enable");

        // R4 / R6 forcing channel 1
        wr(4'd0, 8'h51); tick();
        push(0, 16'h0, "R4 force level 0");
        rd(4'd1, 8'h00, "R6 forcing sets no flag");
        wr(4'd0, 8'h55); tick();
        push(0, 16'h1, "R4 force level 1");
        pwm_mode = 1'b1; wr(4'd0, 8'h51); tick();
        push(0, 16'h1, "R4 force ignored under pwm mode");
        pwm_mode = 1'b0; onepulse_mode = 1'b1; tick();
        push(0, 16'h1, "R4 force ignored under one-pulse mode");
        onepulse_mode = 1'b0; tick();
        push(0, 16'h0, "R4 force resumes");
        push(1, 16'h0, "R6 no irq from forcing");

        // R7 match while forcing
        match_at(16'h2034);
        push(0, 16'h0, "R7 pin stays at forced level");
        rd(4'd1, 8'h01, "R7 flag set by match while forcing");
        push(1, 16'h1, "R7 irq from match while forcing");
        rd(4'd3, 8'h34, "R9 clearing access");

        // R5 channel 2 forcing under both modes
        pwm_mode = 1'b1; onepulse_mode = 1'b1;
        wr(4'd0, 8'h7B); tick();
        push(0, 16'h2, "R5 channel 2 forced high under modes");
        wr(4'd0, 8'h73); tick();
        push(0, 16'h0, "R5 channel 2 forced low");
        pwm_mode = 1'b0; onepulse_mode = 1'b0;

        // R10 enable gating
        wr(4'd0, 8'h02);
        wr(4'd4, 8'h30); wr(4'd5, 8'h00);
        match_at(16'h3000);
        push(1, 16'h0, "R10 no irq without enable");
        rd(4'd1, 8'h02, "R10 channel 2 flag pending");
        wr(4'd0, 8'h82);
        push(1, 16'h1, "R10 irq once enabled");
        rd(4'd5, 8'h00, "R9 clearing access ch2");
        push(1, 16'h0, "R10 irq dropped after clear");

        // R11 capture lock
        cap_at(0, 16'hABCD);
        rd(4'd6, 8'hAB, "R11 capture upper byte");
        rd(4'd7, 8'hCD, "R11 capture lower byte");
        rd(4'd6, 8'hAB, "R11 upper read locks");
        cap_at(0, 16'h5555);
        rd(4'd7, 8'hCD, "R11 locked capture unchanged");
        cap_at(0, 16'h7777);
        rd(4'd6, 8'h77, "R11 capture after unlock");
        rd(4'd7, 8'h77, "R11 capture lower after unlock");
        cap_at(1, 16'h1357);
        rd(4'd9, 8'h57, "R11 channel 2 capture");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule